// File: doc/BRIEF.md
# Byte-Wide Host to Word-Wide Disk Bridge

This block connects a host with an 8-bit I/O bus to a disk drive whose task-file interface is 16 bits wide. The host sees a window of sixteen byte-wide I/O locations. The window's base is fixed by a parameter, and 0x300 or 0x360 are the usual choices. Each location either passes a byte through to a drive register, reaches the drive's control block, or touches a private high-byte holding register. The holding register lets the drive's 16-bit data port be reached as two byte cycles.

To read a data word, the host reads offset 0 and then offset 8. The first read fetches the whole word from the drive, returns the low half and keeps the upper half for the second read, which causes no drive traffic. To write a word the order is reversed. The host first deposits the upper byte at offset 8, and then writes the lower byte at offset 0, which sends the combined word to the drive. Every host access is a one-cycle request pulse, and the block answers it with a one-cycle completion pulse. Each drive access holds its chip select, register address and strobe for a parameter-set number of clock cycles.

Top module: `isa_ide_bridge`

## Requirements
- R1: Only requests whose address bits above bit 3 equal those of the base parameter are served. Any other request gives no completion pulse and no drive cycle.
- R2: A read at offset 0 issues one 16-bit read with the command chip select and register address 0. The host gets bits [7:0], and bits [15:8] go into the holding register.
- R3: A read at offset 8 returns the holding register and causes no drive cycle.
- R4: A write at offset 8 loads the holding register and causes no drive cycle. A write at offset 0 issues one 16-bit drive write whose bits [15:8] are the holding register and whose bits [7:0] are the host byte.
- R5: Offsets 1 to 7 become one byte access with the command chip select and register address equal to the offset. A write drives the host byte on bits [7:0], and a read returns bits [7:0].
- R6: Offset 0xE becomes one access with the control chip select and register address 6. A write sets the device-control byte, and a read returns the alternate status byte.
- R7: Reads at offsets 9 to 0xD and 0xF return 0xFF. Writes there are dropped. Neither causes a drive cycle.
- R8: Each drive access asserts exactly one read or write strobe, held high for STROBE_CYCLES consecutive clocks together with a chip select.
- R9: While reset is low, and right after it, all strobes, chip selects and the completion pulse are low and the holding register is 0x00.
- R10: The holding register changes only on a read of offset 0 or a write of offset 8.
- R11: The completion pulse lasts one cycle. It comes in the cycle after the request when no drive cycle is needed, and otherwise in the cycle after the last strobe cycle, with the read data valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | ADDR_W | Host I/O address |
| hostWrData | input | 8 | Host write byte |
| hostRd | input | 1 | One-cycle read request |
| hostWr | input | 1 | One-cycle write request |
| hostRdData | output | 8 | Read result, valid with hostDone |
| hostDone | output | 1 | One-cycle completion pulse |
| ideDataIn | input | 16 | Data from the drive |
| ideDataOut | output | 16 | Data to the drive |
| ideDataOe | output | 1 | Drive data bus output enable |
| ideCsCmd | output | 1 | Command-block select, active high |
| ideCsCtl | output | 1 | Control-block select, active high |
| ideAddr | output | 3 | Drive register address |
| ideRd | output | 1 | Drive read strobe, active high |
| ideWr | output | 1 | Drive write strobe, active high |

## Verification
A request that is accepted in cycle c completes in cycle c+1 when it needs no drive access. A drive access holds its strobe through cycles c+1 to c+STROBE_CYCLES and completes in cycle c+STROBE_CYCLES+1. The driver records the cycle in which it raises each request and queues the completion cycle it predicts from that. The monitor compares that prediction, the number of strobe pulses and their width, and the read byte at the falling edge of the completion cycle. For an out-of-window request, the bench watches for ten cycles and expects neither a pulse nor a completion.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef enum logic [2:0] {
    ACC_WORD,
    ACC_BYTE,
    ACC_CTL,
    ACC_LATCH,
    ACC_NONE
  } accKind_t;

  typedef struct packed {
    logic acceptReq;
    logic latchFromHost;
    logic latchFromDrive;
    logic rdFromDrive;
    logic rdFromLatch;
    logic rdOnes;
  } dpStrobe_t;

  localparam logic [2:0] CTL_REG = 3'd6;

  function automatic accKind_t classifyOffset(input logic [3:0] off);
    if (off == 4'h0)      return ACC_WORD;
    else if (off <= 4'h7) return ACC_BYTE;
    else if (off == 4'h8) return ACC_LATCH;
    else if (off == 4'hE) return ACC_CTL;
    else                  return ACC_NONE;
  endfunction

  function automatic logic needsDrive(input accKind_t k);
    return (k == ACC_WORD) || (k == ACC_BYTE) || (k == ACC_CTL);
  endfunction

endpackage

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h300,
  parameter int STROBE_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostRd,
  input  logic              hostWr,
  output dpStrobe_t         strb,
  output logic              hostDone,
  output logic              ideCsCmd,
  output logic              ideCsCtl,
  output logic [2:0]        ideAddr,
  output logic              ideRd,
  output logic              ideWr,
  output logic              ideDataOe
);

  localparam int CNT_W = (STROBE_CYCLES > 1) ? $clog2(STROBE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STROBE_CYCLES - 1);
  localparam logic [ADDR_W-5:0] BASE_PAGE = BASE_ADDR[ADDR_W-1:4];

  typedef enum logic [1:0] {ST_IDLE, ST_STROBE, ST_DONE} state_t;

  state_t     state;
  accKind_t   kindQ;
  logic       isWrQ;
  logic [2:0] regAddrQ;
  logic [CNT_W-1:0] cnt;

  accKind_t kindNow;
  logic     inWindow;
  logic     acceptNow;
  logic     lastStrobe;
  logic     isDriveKind;

  assign kindNow    = classifyOffset(hostAddr[3:0]);
  assign inWindow   = (hostAddr[ADDR_W-1:4] == BASE_PAGE);
  assign acceptNow  = (state == ST_IDLE) && (hostRd || hostWr) && inWindow;
  assign lastStrobe = (state == ST_STROBE) && (cnt == LAST_CNT);
  assign isDriveKind = (kindQ == ACC_WORD) || (kindQ == ACC_BYTE);

  always_comb begin
    strb.acceptReq      = acceptNow;
    strb.latchFromHost  = acceptNow && hostWr && (kindNow == ACC_LATCH);
    strb.rdFromLatch    = acceptNow && !hostWr && (kindNow == ACC_LATCH);
    strb.rdOnes         = acceptNow && !hostWr && (kindNow == ACC_NONE);
    strb.rdFromDrive    = lastStrobe && !isWrQ;
    strb.latchFromDrive = lastStrobe && !isWrQ && (kindQ == ACC_WORD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      kindQ    <= ACC_NONE;
      isWrQ    <= 1'b0;
      regAddrQ <= '0;
      cnt      <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (acceptNow) begin
            kindQ    <= kindNow;
            isWrQ    <= hostWr;
            regAddrQ <= (kindNow == ACC_CTL) ? CTL_REG : hostAddr[2:0];
            cnt      <= '0;
            state    <= needsDrive(kindNow) ? ST_STROBE : ST_DONE;
          end
        end
        ST_STROBE: begin
          if (lastStrobe) state <= ST_DONE;
          else            cnt   <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign hostDone  = (state == ST_DONE);
  assign ideCsCmd  = (state == ST_STROBE) && isDriveKind;
  assign ideCsCtl  = (state == ST_STROBE) && (kindQ == ACC_CTL);
  assign ideAddr   = (state == ST_STROBE) ? regAddrQ : 3'd0;
  assign ideRd     = (state == ST_STROBE) && !isWrQ;
  assign ideWr     = (state == ST_STROBE) && isWrQ;
  assign ideDataOe = ideWr;

  assert_strobe_mutex_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(ideRd && ideWr));
  assert_strobe_has_cs_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ideRd || ideWr) |-> (ideCsCmd || ideCsCtl));
  assert_cs_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ideCsCmd, ideCsCtl}));
  assert_ctl_addr_R6: assert property (@(posedge clk) disable iff (!rstN)
    ideCsCtl |-> (ideAddr == CTL_REG));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |=> !hostDone);
  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |-> !(ideRd || ideWr));

endmodule

// File: rtl/bridge_datapath.sv
module bridge_datapath
  import bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   strb,
  input  logic [7:0]  hostWrData,
  input  logic [15:0] ideDataIn,
  output logic [7:0]  hostRdData,
  output logic [15:0] ideDataOut
);

  logic [7:0] latchQ;
  logic [7:0] wrByteQ;
  logic [7:0] rdByteQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ  <= 8'h00;
      wrByteQ <= 8'h00;
      rdByteQ <= 8'h00;
    end else begin
      if (strb.acceptReq)      wrByteQ <= hostWrData;
      if (strb.latchFromHost)  latchQ  <= hostWrData;
      if (strb.latchFromDrive) latchQ  <= ideDataIn[15:8];
      if (strb.rdFromDrive)      rdByteQ <= ideDataIn[7:0];
      else if (strb.rdFromLatch) rdByteQ <= latchQ;
      else if (strb.rdOnes)      rdByteQ <= 8'hFF;
    end
  end

  assign hostRdData = rdByteQ;
  assign ideDataOut = {latchQ, wrByteQ};

  assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.latchFromHost || strb.latchFromDrive) |=> $stable(latchQ));
  assert_latch_one_src_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.latchFromHost && strb.latchFromDrive));

endmodule

// File: rtl/isa_ide_bridge.sv
module isa_ide_bridge
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h300,
  parameter int STROBE_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostWrData,
  input  logic              hostRd,
  input  logic              hostWr,
  output logic [7:0]        hostRdData,
  output logic              hostDone,
  input  logic [15:0]       ideDataIn,
  output logic [15:0]       ideDataOut,
  output logic              ideDataOe,
  output logic              ideCsCmd,
  output logic              ideCsCtl,
  output logic [2:0]        ideAddr,
  output logic              ideRd,
  output logic              ideWr
);

  dpStrobe_t strb;

  bridge_ctrl #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .STROBE_CYCLES(STROBE_CYCLES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr),
    .strb(strb), .hostDone(hostDone), .ideCsCmd(ideCsCmd), .ideCsCtl(ideCsCtl),
    .ideAddr(ideAddr), .ideRd(ideRd), .ideWr(ideWr), .ideDataOe(ideDataOe)
  );

  bridge_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .hostWrData(hostWrData),
    .ideDataIn(ideDataIn), .hostRdData(hostRdData), .ideDataOut(ideDataOut)
  );

endmodule

// File: tb/isa_ide_bridge_tb_top.sv
module isa_ide_bridge_tb_top;

  localparam int S = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] hostAddr = '0;
  logic [7:0]  hostWrData = '0;
  logic        hostRd = 1'b0;
  logic        hostWr = 1'b0;
  logic [7:0]  hostRdData;
  logic        hostDone;
  logic [15:0] ideDataIn;
  logic [15:0] ideDataOut;
  logic        ideDataOe, ideCsCmd, ideCsCtl, ideRd, ideWr;
  logic [2:0]  ideAddr;

  always #2.5 clk = ~clk;

  isa_ide_bridge #(.ADDR_W(16), .BASE_ADDR(16'h0300), .STROBE_CYCLES(S)) dut_i (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostRd(hostRd), .hostWr(hostWr), .hostRdData(hostRdData), .hostDone(hostDone),
    .ideDataIn(ideDataIn), .ideDataOut(ideDataOut), .ideDataOe(ideDataOe),
    .ideCsCmd(ideCsCmd), .ideCsCtl(ideCsCtl), .ideAddr(ideAddr),
    .ideRd(ideRd), .ideWr(ideWr)
  );

  // drive model
  logic [15:0] modelWord;
  logic [7:0]  modelRegs [8];
  logic [7:0]  modelAlt;
  logic [7:0]  modelDevCtl;

  assign ideDataIn = ideCsCmd ? ((ideAddr == 3'd0) ? modelWord : {8'hEE, modelRegs[ideAddr]})
                   : ideCsCtl ? {8'hEE, modelAlt} : 16'h0000;

  always @(negedge clk) begin
    if (ideWr) begin
      if (ideCsCmd) begin
        if (ideAddr == 3'd0) modelWord <= ideDataOut;
        else                 modelRegs[ideAddr] <= ideDataOut[7:0];
      end else if (ideCsCtl && ideAddr == 3'd6) begin
        modelDevCtl <= ideDataOut[7:0];
      end
    end
  end

  int nChecks = 0;
  int nFail = 0;
  int cycleCnt = 0;
  int runLen = 0;
  int pulsesSince = 0;
  int totalPulses = 0;
  int doneCount = 0;

  always @(posedge clk) cycleCnt++;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  typedef struct {
    bit         isRead;
    logic [7:0] expData;
    int         expDone;
    int         expPulses;
    string      tag;
  } sbItem_t;

  sbItem_t sbQ[$];
  sbItem_t it;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (ideRd || ideWr) runLen++;
      else if (runLen != 0) begin
        check(runLen == S, "R8", "strobe width", runLen, S);
        pulsesSince++;
        totalPulses++;
        runLen = 0;
      end
      if (hostDone) begin
        doneCount++;
        if (sbQ.size() == 0) check(1'b0, "R1", "unexpected completion", 1, 0);
        else begin
          it = sbQ.pop_front();
          check(cycleCnt == it.expDone, "R11", "completion cycle", cycleCnt, it.expDone);
          check(pulsesSince == it.expPulses, "R8", "drive pulses", pulsesSince, it.expPulses);
          if (it.isRead)
            check(hostRdData == it.expData, it.tag, "read data", hostRdData, it.expData);
        end
        pulsesSince = 0;
      end
    end
  end

  task automatic access(input bit wr, input logic [15:0] addr, input logic [7:0] d,
                        input logic [7:0] exp, input int pulses, input string tag);
    sbItem_t item;
    @(negedge clk);
    item.isRead = !wr;
    item.expData = exp;
    item.expDone = cycleCnt + 1 + pulses * S;
    item.expPulses = pulses;
    item.tag = tag;
    sbQ.push_back(item);
    hostAddr = addr; hostWrData = d; hostRd = !wr; hostWr = wr;
    @(negedge clk);
    hostRd = 1'b0; hostWr = 1'b0;
    while (sbQ.size() != 0) @(posedge clk);
  endtask

  task automatic outsideAccess(input bit wr, input logic [15:0] addr);
    int p0, d0;
    @(negedge clk);
    p0 = totalPulses; d0 = doneCount;
    hostAddr = addr; hostRd = !wr; hostWr = wr; hostWrData = 8'h99;
    @(negedge clk);
    hostRd = 1'b0; hostWr = 1'b0;
    repeat (10) @(negedge clk);
    check(totalPulses == p0 && runLen == 0, "R1", "drive pulses outside window", totalPulses - p0, 0);
    check(doneCount == d0, "R1", "completions outside window", doneCount - d0, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin : stim
    modelWord = 16'hBEEF;
    for (int i = 0; i < 8; i++) modelRegs[i] = 8'h00;
    modelAlt = 8'h50;
    modelDevCtl = 8'h00;

    // R9: reset state
    repeat (3) begin
      @(negedge clk);
      check(!ideRd && !ideWr && !ideCsCmd && !ideCsCtl && !hostDone, "R9", "outputs in reset",
            {ideRd, ideWr, ideCsCmd, ideCsCtl, hostDone}, 0);
    end
    rstN = 1'b1;
    @(negedge clk);
    check(!ideRd && !ideWr && !ideCsCmd && !ideCsCtl && !hostDone, "R9", "outputs after reset",
          {ideRd, ideWr, ideCsCmd, ideCsCtl, hostDone}, 0);
    access(1'b0, 16'h0308, 8'h00, 8'h00, 0, "R9");

    // R5: byte registers 1..7
    for (int i = 1; i < 8; i++)
      access(1'b1, 16'h0300 + 16'(i), 8'h10 + 8'(i), 8'h00, 1, "R5");
    for (int i = 1; i < 8; i++)
      check(modelRegs[i] == 8'h10 + 8'(i), "R5", "drive byte register", modelRegs[i], 8'h10 + 8'(i));
    access(1'b0, 16'h0303, 8'h00, 8'h13, 1, "R5");
    access(1'b0, 16'h0307, 8'h00, 8'h17, 1, "R5");

    // R2 / R3: word read then latch read
    access(1'b0, 16'h0300, 8'h00, 8'hEF, 1, "R2");
    access(1'b0, 16'h0308, 8'h00, 8'hBE, 0, "R3");

    // R10: other offsets leave the latch alone
    access(1'b0, 16'h0305, 8'h00, 8'h15, 1, "R10");
    access(1'b1, 16'h0304, 8'h44, 8'h00, 1, "R10");
    access(1'b0, 16'h030E, 8'h00, 8'h50, 1, "R10");
    access(1'b0, 16'h0308, 8'h00, 8'hBE, 0, "R10");

    // R4: word write through the latch
    access(1'b1, 16'h0308, 8'h12, 8'h00, 0, "R4");
    check(modelWord == 16'hBEEF, "R4", "word untouched by latch write", modelWord, 16'hBEEF);
    access(1'b1, 16'h0300, 8'h34, 8'h00, 1, "R4");
    check(modelWord == 16'h1234, "R4", "drive word", modelWord, 16'h1234);
    access(1'b0, 16'h0308, 8'h00, 8'h12, 0, "R4");
    access(1'b1, 16'h0300, 8'h56, 8'h00, 1, "R4");
    check(modelWord == 16'h1256, "R4", "second drive word", modelWord, 16'h1256);

    // R6: control block
    access(1'b1, 16'h030E, 8'h0A, 8'h00, 1, "R6");
    check(modelDevCtl == 8'h0A, "R6", "device control", modelDevCtl, 8'h0A);
    check(modelRegs[6] == 8'h16, "R6", "command reg 6 untouched", modelRegs[6], 8'h16);
    modelAlt = 8'hC1;
    access(1'b0, 16'h030E, 8'h00, 8'hC1, 1, "R6");

    // R7: unused offsets
    for (int i = 9; i < 16; i++)
      if (i != 14) access(1'b0, 16'h0300 + 16'(i), 8'h00, 8'hFF, 0, "R7");
    access(1'b1, 16'h030B, 8'h77, 8'h00, 0, "R7");
    access(1'b1, 16'h030F, 8'h78, 8'h00, 0, "R7");
    check(modelWord == 16'h1256, "R7", "word after dropped writes", modelWord, 16'h1256);
    access(1'b0, 16'h0308, 8'h00, 8'h12, 0, "R7");

    // R1: outside the window
    outsideAccess(1'b0, 16'h0360);
    outsideAccess(1'b1, 16'h0310);
    outsideAccess(1'b0, 16'h1300);
    access(1'b0, 16'h0302, 8'h00, 8'h12, 1, "R1");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule